// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block keeps the feedback-divide value, the post-divide code and the test-select code for a frequency synthesizer. Two sources can load them. The parallel source uses a lock pin. While the lock pin is low, the configuration registers follow the parallel divide inputs on every clock and the test-select code is held at zero. When the lock pin goes high, the registers keep the last values they took.

The serial source is three wires: a data line, a shift clock and a commit strobe. The shift clock moves the data line into a 14-bit shift register. A falling edge on the commit strobe then writes the whole word into the registers. The parallel source always wins, so a commit only takes effect while the lock pin is high.

All pins are sampled on the system clock. The serial shift clock and the strobe are edge-detected against their values at the previous clock. Every output comes from a register.

Top module: `divcfg_loader`

## Requirements
- R1: While `par_lock` is sampled low, `m_div` and `n_code` equal the `par_m` and `par_n` values sampled at the same clock edge. They are visible one clock later.
- R2: While `par_lock` is high, the outputs hold the values loaded at the last edge at which `par_lock` was sampled low. A change of `par_m` in the same cycle that `par_lock` rises is not taken.
- R3: `t_sel` is 000 one clock after any edge at which `par_lock` is sampled low. The only way to give it a non-zero value is a serial commit.
- R4: A rising edge of `ser_clk` (sampled high at this clock, low at the previous one) shifts `ser_data` into the least significant end of the 14-bit shift register.
- R5: The serial stream is sent in this order: test code, then post-divide code, then feedback value, each field MSB first. After 14 shifts, register bits [13:11] are T, bits [10:9] are N and bits [8:0] are M.
- R6: A falling edge of `ser_strobe` (sampled low, high at the previous clock) while `par_lock` is high copies the shift register into `t_sel`, `n_code` and `m_div` one clock later.
- R7: A falling edge of `ser_strobe` while `par_lock` is low has no effect. The outputs keep following the parallel inputs and `t_sel` stays 000.
- R8: Shifting without a falling edge of `ser_strobe` leaves all outputs unchanged.
- R9: Synchronous reset sets `m_div` to all ones, `n_code` to 11 and `t_sel` to 000, and clears the shift register. A commit made right after reset with no shifting therefore yields all zeros.
- R10: When a `ser_strobe` falling edge and a `ser_clk` rising edge fall on the same clock, the commit takes the contents from before that shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_lock | input | 1 | Low: parallel values flow through; high: hold |
| par_m | input | 9 | Parallel feedback-divide value |
| par_n | input | 2 | Parallel post-divide code |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Serial commit strobe; falling edge commits |
| m_div | output | 9 | Current feedback-divide value |
| n_code | output | 2 | Current post-divide code |
| t_sel | output | 3 | Current test-select code |

## Verification
Two events can land on the same clock: a commit-strobe falling edge and a shift-clock rising edge. The bench fully loads one word, then drops the strobe at the same sampled edge that raises the shift clock with a new bit. It expects the committed outputs to be the word from before that shift. A second commit then has to show the word shifted by one position with the new bit at the bottom. A strobe fall while the lock pin is low is also provoked, and the outputs are judged to still track the parallel pins with a zero test code.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W_DEF = 9;
  localparam int N_W_DEF = 2;
  localparam int T_W_DEF = 3;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_SER  = 2'd2
  } src_e;
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = sig[i] & ~prev_q[i];
    assign fall[i] = ~sig[i] & prev_q[i];
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/cfg_hold_reg.sv
module cfg_hold_reg
  import divcfg_pkg::*;
#(
  parameter int M_W = M_W_DEF,
  parameter int N_W = N_W_DEF,
  parameter int T_W = T_W_DEF,
  localparam int SH_W = M_W + N_W + T_W
) (
  input  logic            clk,
  input  logic            rst,
  input  src_e            src,
  input  logic [M_W-1:0]  par_m,
  input  logic [N_W-1:0]  par_n,
  input  logic [SH_W-1:0] ser_word,
  output logic [M_W-1:0]  m_q,
  output logic [N_W-1:0]  n_q,
  output logic [T_W-1:0]  t_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '1;
      n_q <= '1;
      t_q <= '0;
    end else begin
      case (src)
        SRC_PAR: begin
          m_q <= par_m;
          n_q <= par_n;
          t_q <= '0;
        end
        SRC_SER: begin
          m_q <= ser_word[M_W-1:0];
          n_q <= ser_word[M_W+N_W-1:M_W];
          t_q <= ser_word[SH_W-1:M_W+N_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int M_W = M_W_DEF,
  parameter int N_W = N_W_DEF,
  parameter int T_W = T_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_lock,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_strobe,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel
);
  localparam int SH_W = M_W + N_W + T_W;

  logic [1:0]      rise, fall;
  logic [SH_W-1:0] sh_q;
  src_e            src;

  cfg_edge_det #(.W(2)) u_edge (
    .clk (clk),
    .rst (rst),
    .sig ({ser_strobe, ser_clk}),
    .rise(rise),
    .fall(fall)
  );

  cfg_shift #(.W(SH_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(rise[0]),
    .din     (ser_data),
    .q       (sh_q)
  );

  always_comb begin
    if (!par_lock)    src = SRC_PAR;
    else if (fall[1]) src = SRC_SER;
    else              src = SRC_HOLD;
  end

  cfg_hold_reg #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .src     (src),
    .par_m   (par_m),
    .par_n   (par_n),
    .ser_word(sh_q),
    .m_q     (m_div),
    .n_q     (n_code),
    .t_q     (t_sel)
  );
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int SH_W = M_W + N_W + T_W
) (
  input logic            clk,
  input logic            rst,
  input logic            par_lock,
  input logic [M_W-1:0]  par_m,
  input logic [N_W-1:0]  par_n,
  input logic            ser_strobe,
  input logic [SH_W-1:0] sh_q,
  input logic [M_W-1:0]  m_div,
  input logic [N_W-1:0]  n_code,
  input logic [T_W-1:0]  t_sel
);
  logic past_ok, strb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      strb_q  <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      strb_q  <= ser_strobe;
    end
  end

  assert_follow_par_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(par_lock)) |-> (m_div == $past(par_m) && n_code == $past(par_n)));

  assert_test_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(par_lock)) |-> (t_sel == '0));

  // R2 and R8: nothing changes without the parallel path or a commit
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(par_lock) && !$past(strb_q && !ser_strobe))
      |-> ($stable(m_div) && $stable(n_code) && $stable(t_sel)));

  assert_commit_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(par_lock && strb_q && !ser_strobe))
      |-> ({t_sel, n_code, m_div} == $past(sh_q)));
endmodule

bind divcfg_loader divcfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .par_lock  (par_lock),
  .par_m     (par_m),
  .par_n     (par_n),
  .ser_strobe(ser_strobe),
  .sh_q      (sh_q),
  .m_div     (m_div),
  .n_code    (n_code),
  .t_sel     (t_sel)
);

// File: tb/test_divcfg_loader.sv
module test_divcfg_loader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_lock = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_strobe = 1'b0;
  logic [8:0] m_div;
  logic [1:0] n_code;
  logic [2:0] t_sel;

  int checks = 0;
  int fails  = 0;
  logic [13:0] exp_sh = '0;

  always #5 clk = ~clk;

  divcfg_loader i_divcfg_loader (
    .clk(clk), .rst(rst), .par_lock(par_lock), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .m_div(m_div), .n_code(n_code), .t_sel(t_sel)
  );

  task automatic chk(input string req, input logic [13:0] exp);
    logic [13:0] act;
    act = {t_sel, n_code, m_div};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
    exp_sh = {exp_sh[12:0], b};
  endtask

  task automatic send_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe();
    @(negedge clk); ser_strobe = 1'b1;
    @(negedge clk); ser_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; par_lock = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_sh = '0;
    @(negedge clk);
    chk("R9 reset values", {3'b000, 2'b11, 9'h1FF});
    strobe();
    chk("R9 cleared shift register commit", 14'h0000);
  endtask

  task automatic t_transparent();
    @(negedge clk); par_lock = 1'b0; par_m = 9'h0A5; par_n = 2'b01;
    @(negedge clk);
    chk("R1 follow parallel", {3'b000, 2'b01, 9'h0A5});
    par_m = 9'h13C; par_n = 2'b10;
    @(negedge clk);
    chk("R1 follow second value", {3'b000, 2'b10, 9'h13C});
    par_lock = 1'b1; par_m = 9'h001; par_n = 2'b11;
    @(negedge clk);
    chk("R2 capture last low value", {3'b000, 2'b10, 9'h13C});
    par_m = 9'h0F0;
    repeat (2) @(negedge clk);
    chk("R2 hold while locked", {3'b000, 2'b10, 9'h13C});
  endtask

  task automatic t_serial();
    logic [13:0] w;
    w = {3'b101, 2'b01, 9'h1C3};
    send_word(w);
    chk("R8 shift without commit unchanged", {3'b000, 2'b10, 9'h13C});
    strobe();
    chk("R5 R6 serial commit order", w);
    w = {3'b011, 2'b10, 9'h05A};
    send_word(w);
    strobe();
    chk("R4 second serial word", w);
  endtask

  task automatic t_coincide();
    logic [13:0] w;
    w = {3'b110, 2'b11, 9'h0E7};
    send_word(w);
    @(negedge clk); ser_strobe = 1'b1;
    @(negedge clk); ser_strobe = 1'b0; ser_clk = 1'b1; ser_data = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
    exp_sh = {exp_sh[12:0], 1'b1};
    chk("R10 commit takes pre-shift word", w);
    strobe();
    chk("R10 shift still happened", exp_sh);
  endtask

  task automatic t_parallel_priority();
    send_word({3'b111, 2'b00, 9'h111});
    @(negedge clk); par_lock = 1'b0; par_m = 9'h066; par_n = 2'b00;
    ser_strobe = 1'b1;
    @(negedge clk); ser_strobe = 1'b0;
    @(negedge clk);
    chk("R7 strobe ignored while unlocked", {3'b000, 2'b00, 9'h066});
    chk("R3 test code zero while unlocked", {3'b000, n_code, m_div});
    par_lock = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 hold after unlocked strobe", {3'b000, 2'b00, 9'h066});
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_transparent();
    t_serial();
    t_coincide();
    t_parallel_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule